// File: doc/BRIEF.md
# Clock Frequency Readback Decoder

This block works out the frequency, in kHz, at which one clock domain is currently running. It reads the domain's configuration words: two source-control words, the PLL control word and the PLL coefficient word. It also takes the crystal frequency and the frequency of the VCO that feeds the divided-source path. The clock tree it decodes has layers. The domain is either fed straight from an alternate source when the PLL is bypassed, or it is produced by a PLL. That PLL's reference can be the crystal, a fixed 100 or 108 MHz source, or a divided-down VCO.

A caller pulses `start` while the block is idle. The block captures every configuration input in that cycle and then walks the tree. One serial divider is shared between two steps: dividing the VCO for the source, and applying the PLL's multiply/divide. When the block finishes, it raises `done` for one cycle. The 32-bit result stays on `resultKhz` until the next accepted start. The parameter `HAS_POSTDIV` selects whether the PLL has a post-divider. When it has none, the post-divider field is disregarded.

Top module: `clk_freq_readback`

## Requirements
- R1: A start is accepted only while `busy` is low. All configuration inputs are captured in the accepting cycle, so later changes to them, and further starts while busy, have no effect on the result. `busy` stays high until `done`. `done` is high for exactly one cycle per accepted start.
- R2: After reset, `busy`, `done` and `resultKhz` are 0. `resultKhz` keeps its value from the cycle of `done` until the next accepted start.
- R3: A source-control word whose enable bit (bit 8) is 0 yields a source value of 0.
- R4: With the enable bit set, select field bits [13:12] = 0 yields the crystal frequency.
- R5: With the enable bit set, select field = 2 yields 108000 when bit 6 is 1, and 100000 when bit 6 is 0.
- R6: With the enable bit set, select field = 3 yields floor(2 × vcoKhz / (bits[21:16] + 2)). The doubling is done without overflow.
- R7: With the enable bit set, select field = 1 yields 0.
- R8: When PLL control bit 3 (bypass) is 1, the result is the source value of `domainCtl`. The coefficient word and PLL control bit 0 have no effect.
- R9: When bypass is 0 and PLL control bit 0 (enable) is 1, the result is the low 32 bits of floor(ref × N / (M × P)). Here ref is the source value of `refCtl`, M = coef[7:0], N = coef[15:8] and P = coef[21:16]. The product ref × N is formed at 64 bits.
- R10: When bypass and enable are both 0, the result is 0.
- R11: In PLL mode, when M × P = 0 the result is 0.
- R12: With `HAS_POSTDIV` = 0, P is taken as 1 whatever coef[21:16] holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a decode; honoured only when idle |
| crystalKhz | input | 32 | Crystal frequency in kHz |
| vcoKhz | input | 32 | VCO frequency in kHz for the divided-source path |
| domainCtl | input | 32 | Source-control word used when the PLL is bypassed |
| refCtl | input | 32 | Source-control word giving the PLL reference |
| pllCtl | input | 32 | PLL control word (bit 3 bypass, bit 0 enable) |
| pllCoef | input | 32 | PLL coefficients: M [7:0], N [15:8], P [21:16] |
| busy | output | 1 | High from an accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| resultKhz | output | 32 | Decoded frequency in kHz |

## Verification
The bench builds two copies of the block side by side with the same inputs: one with `HAS_POSTDIV` = 1 and one with `HAS_POSTDIV` = 0, both at the default 64-bit dividend and 16-bit divisor widths. Running them together lets one stimulus show both the honoured and the ignored post-divider. This matters most for coefficient words whose P field is zero, where one copy returns 0 and the other divides. The sweeps cover every select value, both enable settings and both fixed-source choices, and divider fields from 0 to 63. A VCO at the 32-bit maximum reaches the 33-bit doubling and the truncation of a 40-bit PLL product.

// File: rtl/clk_freq_pkg.sv
package clk_freq_pkg;

  localparam int KHZ_W  = 32;
  localparam int CTL_W  = 32;
  localparam int PROD_W = 64;
  localparam int DIVR_W = 16;

  // source-control word layout
  localparam int SRC_EN_BIT  = 8;
  localparam int SRC_HI_BIT  = 6;
  localparam int SRC_SEL_LSB = 12;
  localparam int SRC_DIV_LSB = 16;
  localparam int SRC_DIV_W   = 6;
  localparam int DIV_OFFSET  = 2;

  // PLL control and coefficient layout
  localparam int PLL_EN_BIT  = 0;
  localparam int PLL_BYP_BIT = 3;
  localparam int COEF_M_LSB  = 0;
  localparam int COEF_N_LSB  = 8;
  localparam int COEF_P_LSB  = 16;
  localparam int COEF_MN_W   = 8;
  localparam int COEF_P_W    = 6;

  localparam logic [KHZ_W-1:0] FIXED_LO_KHZ = 32'd100000;
  localparam logic [KHZ_W-1:0] FIXED_HI_KHZ = 32'd108000;

  typedef enum logic [1:0] {
    SEL_XTAL  = 2'd0,
    SEL_OFF   = 2'd1,
    SEL_FIXED = 2'd2,
    SEL_VCO   = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    RES_ZERO = 2'd0,
    RES_SRC  = 2'd1,
    RES_QUOT = 2'd2
  } resSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRC, ST_SRC_WAIT, ST_MUL, ST_PLL_WAIT, ST_DONE
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    srcKick;
    logic    srcLatch;
    logic    srcUseQuot;
    logic    pllKick;
    logic    resLoad;
    resSel_e resSel;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pathOff;
    logic bypass;
    logic srcNeedsDiv;
    logic mpZero;
    logic divDone;
  } dpStatus_t;

endpackage

// File: rtl/clk_freq_divider.sv
module clk_freq_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kick,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] q;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] diff;
  logic             borrow;

  always_comb begin
    shifted = {rem[DEN_W-1:0], q[NUM_W-1]};
    diff    = {1'b0, shifted} - {2'b00, den};
    borrow  = diff[DEN_W+1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem  <= '0;
      den  <= '0;
      q    <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (kick) begin
      rem  <= '0;
      den  <= denom;
      q    <= numer;
      cnt  <= CNT_W'(NUM_W);
      done <= 1'b0;
    end else if (cnt != '0) begin
      rem  <= borrow ? shifted : diff[DEN_W:0];
      q    <= {q[NUM_W-2:0], ~borrow};
      cnt  <= cnt - 1'b1;
      done <= (cnt == CNT_W'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = q;
endmodule

// File: rtl/clk_freq_datapath.sv
module clk_freq_datapath
  import clk_freq_pkg::*;
#(
  parameter bit HAS_POSTDIV = 1'b1,
  parameter int KW = KHZ_W,
  parameter int CW = CTL_W,
  parameter int PW = PROD_W,
  parameter int DW = DIVR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [KW-1:0] crystalKhz,
  input  logic [KW-1:0] vcoKhz,
  input  logic [CW-1:0] domainCtl,
  input  logic [CW-1:0] refCtl,
  input  logic [CW-1:0] pllCtl,
  input  logic [CW-1:0] pllCoef,
  output dpStatus_t     status,
  output logic [KW-1:0] resultKhz
);
  logic [KW-1:0] capXtal, capVco;
  logic [CW-1:0] capDom, capRef, capPll, capCoef;
  logic [KW-1:0] srcVal, resReg;

  logic [CW-1:0]          activeCtl;
  srcSel_e                activeSel;
  logic                   activeEn;
  logic [KW-1:0]          srcImm;
  logic [DW-1:0]          srcDivisor;
  logic [COEF_MN_W-1:0]   mVal, nVal;
  logic [COEF_P_W-1:0]    pVal;
  logic [DW-1:0]          mpProd;
  logic [PW-1:0]          vcoNumer, pllNumer;
  logic [PW-1:0]          divNumer, divQuot;
  logic [DW-1:0]          divDenom;
  logic                   divKick, divDone;

  // capture all configuration on an accepted start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capXtal <= '0;
      capVco  <= '0;
      capDom  <= '0;
      capRef  <= '0;
      capPll  <= '0;
      capCoef <= '0;
    end else if (strobe.capture) begin
      capXtal <= crystalKhz;
      capVco  <= vcoKhz;
      capDom  <= domainCtl;
      capRef  <= refCtl;
      capPll  <= pllCtl;
      capCoef <= pllCoef;
    end
  end

  // source decode for whichever word the PLL mode selects
  always_comb begin
    activeCtl = capPll[PLL_BYP_BIT] ? capDom : capRef;
    activeSel = srcSel_e'(activeCtl[SRC_SEL_LSB +: 2]);
    activeEn  = activeCtl[SRC_EN_BIT];
    srcImm    = '0;
    if (activeEn) begin
      unique case (activeSel)
        SEL_XTAL:  srcImm = capXtal;
        SEL_FIXED: srcImm = activeCtl[SRC_HI_BIT] ? FIXED_HI_KHZ : FIXED_LO_KHZ;
        default:   srcImm = '0;
      endcase
    end
    srcDivisor = DW'(activeCtl[SRC_DIV_LSB +: SRC_DIV_W]) + DW'(DIV_OFFSET);
    vcoNumer   = {{(PW-KW-1){1'b0}}, capVco, 1'b0};
  end

  // PLL coefficients, with the post-divider chosen by parameter
  assign mVal = capCoef[COEF_M_LSB +: COEF_MN_W];
  assign nVal = capCoef[COEF_N_LSB +: COEF_MN_W];

  generate
    if (HAS_POSTDIV) begin : gPostDiv
      assign pVal = capCoef[COEF_P_LSB +: COEF_P_W];
    end else begin : gNoPostDiv
      assign pVal = COEF_P_W'(1);
    end
  endgenerate

  assign mpProd   = DW'(mVal) * DW'(pVal);
  assign pllNumer = PW'(srcVal) * PW'(nVal);

  // one divider shared by both steps
  assign divKick  = strobe.srcKick | strobe.pllKick;
  assign divNumer = strobe.srcKick ? vcoNumer : pllNumer;
  assign divDenom = strobe.srcKick ? srcDivisor : mpProd;

  clk_freq_divider #(
    .NUM_W(PW),
    .DEN_W(DW)
  ) uDiv (
    .clk   (clk),
    .rstN  (rstN),
    .kick  (divKick),
    .numer (divNumer),
    .denom (divDenom),
    .quot  (divQuot),
    .done  (divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcVal <= '0;
    end else if (strobe.srcLatch) begin
      srcVal <= strobe.srcUseQuot ? divQuot[KW-1:0] : srcImm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg <= '0;
    end else if (strobe.resLoad) begin
      unique case (strobe.resSel)
        RES_SRC:  resReg <= srcVal;
        RES_QUOT: resReg <= divQuot[KW-1:0];
        default:  resReg <= '0;
      endcase
    end
  end

  assign status.pathOff     = ~capPll[PLL_BYP_BIT] & ~capPll[PLL_EN_BIT];
  assign status.bypass      = capPll[PLL_BYP_BIT];
  assign status.srcNeedsDiv = activeEn & (activeSel == SEL_VCO);
  assign status.mpZero      = (mpProd == '0);
  assign status.divDone     = divDone;
  assign resultKhz          = resReg;
endmodule

// File: rtl/clk_freq_ctrl.sv
module clk_freq_ctrl
  import clk_freq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  ctlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          nextState      = ST_SRC;
        end
      end
      ST_SRC: begin
        if (status.pathOff) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_ZERO;
          nextState      = ST_DONE;
        end else if (status.srcNeedsDiv) begin
          strobe.srcKick = 1'b1;
          nextState      = ST_SRC_WAIT;
        end else begin
          strobe.srcLatch = 1'b1;
          nextState       = ST_MUL;
        end
      end
      ST_SRC_WAIT: begin
        if (status.divDone) begin
          strobe.srcLatch   = 1'b1;
          strobe.srcUseQuot = 1'b1;
          nextState         = ST_MUL;
        end
      end
      ST_MUL: begin
        if (status.bypass) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_SRC;
          nextState      = ST_DONE;
        end else if (status.mpZero) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_ZERO;
          nextState      = ST_DONE;
        end else begin
          strobe.pllKick = 1'b1;
          nextState      = ST_PLL_WAIT;
        end
      end
      ST_PLL_WAIT: begin
        if (status.divDone) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_QUOT;
          nextState      = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/clk_freq_readback.sv
module clk_freq_readback
  import clk_freq_pkg::*;
#(
  parameter bit HAS_POSTDIV = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [KHZ_W-1:0] crystalKhz,
  input  logic [KHZ_W-1:0] vcoKhz,
  input  logic [CTL_W-1:0] domainCtl,
  input  logic [CTL_W-1:0] refCtl,
  input  logic [CTL_W-1:0] pllCtl,
  input  logic [CTL_W-1:0] pllCoef,
  output logic             busy,
  output logic             done,
  output logic [KHZ_W-1:0] resultKhz
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  clk_freq_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  clk_freq_datapath #(
    .HAS_POSTDIV(HAS_POSTDIV)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .crystalKhz (crystalKhz),
    .vcoKhz     (vcoKhz),
    .domainCtl  (domainCtl),
    .refCtl     (refCtl),
    .pllCtl     (pllCtl),
    .pllCoef    (pllCoef),
    .status     (status),
    .resultKhz  (resultKhz)
  );
endmodule

// File: rtl/clk_freq_readback_chk.sv
module clk_freq_readback_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] domainCtl,
  input logic [31:0] pllCtl,
  input logic        busy,
  input logic        done,
  input logic [31:0] resultKhz
);
  logic       capByp, capEn, capDomEn, capDomHi;
  logic [1:0] capDomSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capByp    <= 1'b0;
      capEn     <= 1'b0;
      capDomEn  <= 1'b0;
      capDomHi  <= 1'b0;
      capDomSel <= 2'd0;
    end else if (start && !busy) begin
      capByp    <= pllCtl[3];
      capEn     <= pllCtl[0];
      capDomEn  <= domainCtl[8];
      capDomHi  <= domainCtl[6];
      capDomSel <= domainCtl[13:12];
    end
  end

  a_r1_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(resultKhz));

  a_r3_disabled_src: assert property (@(posedge clk) disable iff (!rstN)
    (done && capByp && !capDomEn) |-> (resultKhz == 32'd0));

  a_r5_fixed_src: assert property (@(posedge clk) disable iff (!rstN)
    (done && capByp && capDomEn && capDomSel == 2'd2) |->
      (resultKhz == (capDomHi ? 32'd108000 : 32'd100000)));

  a_r7_off_select: assert property (@(posedge clk) disable iff (!rstN)
    (done && capByp && capDomEn && capDomSel == 2'd1) |-> (resultKhz == 32'd0));

  a_r10_path_off: assert property (@(posedge clk) disable iff (!rstN)
    (done && !capByp && !capEn) |-> (resultKhz == 32'd0));
endmodule

bind clk_freq_readback clk_freq_readback_chk uChk (.*);

// File: tb/tb_clk_freq_readback.sv
module tb_clk_freq_readback;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] crystalKhz = 32'd27000;
  logic [31:0] vcoKhz = '0;
  logic [31:0] domainCtl = '0, refCtl = '0, pllCtl = '0, pllCoef = '0;
  logic        busyA, doneA, busyB, doneB;
  logic [31:0] resA, resB;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clk_freq_readback #(.HAS_POSTDIV(1'b1)) dut (
    .clk(clk), .rstN(rstN), .start(start), .crystalKhz(crystalKhz),
    .vcoKhz(vcoKhz), .domainCtl(domainCtl), .refCtl(refCtl),
    .pllCtl(pllCtl), .pllCoef(pllCoef),
    .busy(busyA), .done(doneA), .resultKhz(resA));

  clk_freq_readback #(.HAS_POSTDIV(1'b0)) dutNoPost (
    .clk(clk), .rstN(rstN), .start(start), .crystalKhz(crystalKhz),
    .vcoKhz(vcoKhz), .domainCtl(domainCtl), .refCtl(refCtl),
    .pllCtl(pllCtl), .pllCoef(pllCoef),
    .busy(busyB), .done(doneB), .resultKhz(resB));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] srcModel(logic [31:0] xtal, logic [31:0] vco,
                                           logic [31:0] ctl);
    longint unsigned v;
    if (!ctl[8]) return 32'd0;
    case (ctl[13:12])
      2'd0: return xtal;
      2'd1: return 32'd0;
      2'd2: return ctl[6] ? 32'd108000 : 32'd100000;
      default: begin
        v = (longint'(vco) * 2) / (longint'(ctl[21:16]) + 2);
        return v[31:0];
      end
    endcase
  endfunction

  function automatic string srcTag(logic [31:0] ctl);
    if (!ctl[8]) return "R3";
    case (ctl[13:12])
      2'd0: return "R4";
      2'd1: return "R7";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] expModel(bit hasP, logic [31:0] xtal,
      logic [31:0] vco, logic [31:0] dom, logic [31:0] refW,
      logic [31:0] pll, logic [31:0] coef);
    longint unsigned m, n, p, prod, q;
    if (pll[3]) return srcModel(xtal, vco, dom);
    if (!pll[0]) return 32'd0;
    m = longint'(coef[7:0]);
    n = longint'(coef[15:8]);
    p = hasP ? longint'(coef[21:16]) : 1;
    if (m * p == 0) return 32'd0;
    prod = longint'(srcModel(xtal, vco, refW)) * n;
    q = prod / (m * p);
    return q[31:0];
  endfunction

  function automatic string tagModel(bit hasP, logic [31:0] dom,
      logic [31:0] refW, logic [31:0] pll, logic [31:0] coef);
    int p;
    if (pll[3]) return {"R8/", srcTag(dom)};
    if (!pll[0]) return "R10";
    p = hasP ? int'(coef[21:16]) : 1;
    if (int'(coef[7:0]) * p == 0) return hasP ? "R11" : "R11/R12";
    return {hasP ? "R9/" : "R12/", srcTag(refW)};
  endfunction

  task automatic runCase(input logic [31:0] xtal, input logic [31:0] vco,
                         input logic [31:0] dom, input logic [31:0] refW,
                         input logic [31:0] pll, input logic [31:0] coef,
                         input bit scramble);
    logic [31:0] expA, expB, gotA, gotB;
    int dcA, dcB;
    bit fin;
    expA = expModel(1'b1, xtal, vco, dom, refW, pll, coef);
    expB = expModel(1'b0, xtal, vco, dom, refW, pll, coef);
    gotA = '0;
    gotB = '0;
    @(negedge clk);
    crystalKhz = xtal; vcoKhz = vco; domainCtl = dom;
    refCtl = refW; pllCtl = pll; pllCoef = coef;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      // R1: inputs moved and a second start while busy must not matter
      crystalKhz = ~xtal; vcoKhz = ~vco; domainCtl = ~dom;
      refCtl = ~refW; pllCtl = 32'h8; pllCoef = ~coef;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    dcA = 0; dcB = 0; fin = 1'b0;
    for (int i = 0; i < 400 && !fin; i++) begin
      if (doneA) begin dcA++; gotA = resA; end
      if (doneB) begin dcB++; gotB = resB; end
      if (!busyA && !busyB && dcA > 0 && dcB > 0) fin = 1'b1;
      else @(negedge clk);
    end
    check(fin, "R1", "completion", {31'd0, fin}, 32'd1);
    check(dcA == 1, "R1", "done pulse cycles (postdiv)", dcA, 32'd1);
    check(dcB == 1, "R1", "done pulse cycles (no postdiv)", dcB, 32'd1);
    check(gotA == expA, tagModel(1'b1, dom, refW, pll, coef), "result postdiv", gotA, expA);
    check(gotB == expB, tagModel(1'b0, dom, refW, pll, coef), "result no postdiv", gotB, expB);
    repeat (2) @(negedge clk);
    check(resA == gotA, "R2", "hold postdiv", resA, gotA);
    check(resB == gotB, "R2", "hold no postdiv", resB, gotB);
  endtask

  function automatic logic [31:0] coefAt(int i);
    case (i)
      0:  return {10'd0, 6'd1,  8'd1,   8'd1};
      1:  return {10'd0, 6'd1,  8'd27,  8'd2};
      2:  return {10'd0, 6'd2,  8'd100, 8'd3};
      3:  return {10'd0, 6'd1,  8'd50,  8'd0};
      4:  return {10'd0, 6'd0,  8'd50,  8'd5};
      5:  return {10'd0, 6'd63, 8'd255, 8'd255};
      6:  return {10'd0, 6'd1,  8'd255, 8'd1};
      7:  return {10'd0, 6'd3,  8'd0,   8'd7};
      8:  return {10'h3ff, 6'd4, 8'd200, 8'd13};
      9:  return {10'd0, 6'd63, 8'd128, 8'd1};
      10: return {10'd0, 6'd5,  8'd3,   8'd128};
      default: return {10'd0, 6'd2, 8'd77, 8'd9};
    endcase
  endfunction

  function automatic logic [31:0] refAt(int i);
    case (i)
      0: return 32'h0000_0100;
      1: return 32'h0000_2100;
      2: return 32'h0000_2140;
      3: return 32'h0000_3100;
      4: return 32'h003f_3100;
      5: return 32'h0000_2000;
      6: return 32'h0000_1100;
      default: return 32'h0007_3140;
    endcase
  endfunction

  function automatic logic [5:0] divAt(int i);
    case (i)
      0: return 6'd0;
      1: return 6'd1;
      2: return 6'd13;
      default: return 6'd63;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vcos [2];
    vcos[0] = 32'd1620000;
    vcos[1] = 32'hffff_ffff;

    repeat (4) @(negedge clk);
    // R2: reset state
    check(!busyA && !doneA, "R2", "busy/done in reset", {30'd0, busyA, doneA}, 32'd0);
    check(resA == 0 && resB == 0, "R2", "result in reset", resA | resB, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyA && !busyB && !doneA && !doneB, "R2", "idle after reset",
          {28'd0, busyA, busyB, doneA, doneB}, 32'd0);

    for (int v = 0; v < 2; v++) begin
      // bypass sweep over the domain source word (R3..R8)
      for (int en = 0; en < 2; en++)
        for (int sel = 0; sel < 4; sel++)
          for (int hi = 0; hi < 2; hi++)
            for (int d = 0; d < 4; d++)
              runCase((v == 0) ? 32'd27000 : 32'd25000, vcos[v],
                      {10'd0, divAt(d), 2'(sel), 3'd0, 1'(en), 1'b0, 1'(hi), 6'd0},
                      refAt(d), (en == 1) ? 32'h9 : 32'h8, coefAt(sel * 2 + hi), 1'b0);
      // PLL sweep (R9, R11, R12)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 12; c++)
          runCase(32'd27000, vcos[v], 32'h0000_2140, refAt(r),
                  32'h1 | (32'(c & 1) << 4), coefAt(c), 1'b0);
    end

    // R10: neither bypass nor enable
    runCase(32'd27000, vcos[0], 32'h100, 32'h100, 32'h0,  coefAt(1), 1'b0);
    runCase(32'd27000, vcos[0], 32'h100, 32'h100, 32'h10, coefAt(2), 1'b0);
    runCase(32'd27000, vcos[0], 32'h100, 32'h3100, 32'h4, coefAt(6), 1'b0);
    runCase(32'd27000, vcos[1], 32'h100, 32'h3100, 32'h14, coefAt(9), 1'b0);

    // R1: changes after acceptance ignored
    runCase(32'd27000, vcos[0], 32'h2100, 32'h0005_3100, 32'h1, coefAt(2), 1'b1);
    runCase(32'd25000, vcos[1], 32'h0100, 32'h0000_0100, 32'h1, coefAt(11), 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule